// File: doc/BRIEF.md
# I2C Target with 16-bit Word Registers

This block is an I2C target that lets a bus host reach a bank of 16-bit registers held elsewhere in the chip. The bus lines are brought into the system clock domain. The block then finds start, repeated start and stop conditions and checks a 7-bit device address whose two lowest bits are ignored. A write transaction first loads a two-byte register pointer. Any further bytes in that transaction are taken as data words, each sent most significant byte first. A read transaction returns words from the current pointer. The pointer steps by one for every word moved, so one transaction can carry several words.

On the core side the block offers a plain synchronous register port. It gives a pointer-driven address, a one-cycle write strobe with a 16-bit write word, and a one-cycle read strobe. The data for a read is expected on the cycle that follows the read strobe. SDA is driven only low, through an output enable that the pad turns into an open-drain pull-down. The SCL low and high phases must each last at least six system clock cycles.

Top module: `i2c_word_target`

## Requirements
- R1: A falling SDA while SCL is high is a start and restarts address reception. A rising SDA while SCL is high is a stop: the block returns to idle and stops driving SDA.
- R2: An address byte whose upper seven bits match 0101_1xx (the two lowest address bits are don't-care) is acknowledged with SDA low. Any other address is not acknowledged, and every later byte is ignored until the next start.
- R3: The eighth bit of the address byte picks the direction: 1 reads and 0 writes.
- R4: After a write header, the next two bytes set the pointer, bits [15:8] first and then bits [7:0], and each byte is acknowledged. Only pointer bits [9:0] are kept; bits [15:10] are ignored.
- R5: Each data word of a write arrives high byte first. It is committed as a single-cycle reg_we_o pulse, with reg_addr_o set to the pointer and reg_wdata_o set to {high, low}, only after its low byte has been received. Every data byte is acknowledged.
- R6: The pointer steps by one after each committed word and wraps from 0x3FF to 0x000.
- R7: A read header after a repeated start returns the word at the pointer that the preceding write loaded, high byte first and MSB first.
- R8: A read header in a new transaction after a stop reads from the pointer left by the earlier transaction.
- R9: While the host acknowledges low bytes, reading continues with the following words. A not-acknowledged byte makes the block release SDA and wait for a start or a stop. After the read, reg_addr_o points one past the last word sent.
- R10: A data word cut short by a stop or a start, after only its high byte, is not written.
- R11: sda_oe_o changes only while SCL is low.
- R12: reg_re_o is a single-cycle pulse, reg_rdata_i is taken on the cycle after it, and reg_we_o and reg_re_o are never high together.
- R13: In reset, sda_oe_o, reg_we_o and reg_re_o are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| reg_addr_o | output | 10 | Register pointer |
| reg_wdata_o | output | 16 | Word to write |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_re_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | 16 | Read word, valid the cycle after reg_re_o |

## Verification
The host model sends several patterns, and each one is meant to expose a different kind of fault. A two-word write at a low pointer, followed by a repeated-start read of the same words, checks byte order and pointer stepping in both directions. A header that uses the other don't-care address bits, together with a pointer high byte full of junk bits, checks the address mask and the pointer truncation. A foreign device address, a high byte aborted by a stop, and a separate read after a stop show that nothing leaks into the register bank. A write at 0x3FF shows the pointer wrapping to zero.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } state_t;

  typedef enum logic [2:0] {
    RL_DEV,
    RL_PTR_HI,
    RL_PTR_LO,
    RL_DAT_HI,
    RL_DAT_LO,
    RL_RD
  } role_t;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_word_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o,
  output logic     sda_s_o
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_q, sda_q;
  logic              scl_s, sda_s;

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_comb begin
    evt_o.scl_rise = scl_s & ~scl_q;
    evt_o.scl_fall = ~scl_s & scl_q;
    evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
    evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

  assign sda_s_o = sda_s;

endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic              inc_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] ptr_o
);

  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0]   hi_q, hi_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;

  always_comb begin
    hi_n  = hi_q;
    ptr_n = ptr_q;
    if (ld_hi_i) hi_n = byte_i[HI_W-1:0];
    if (ld_lo_i)      ptr_n = {hi_q, byte_i};
    else if (inc_i)   ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      ptr_q <= '0;
    end else begin
      hi_q  <= hi_n;
      ptr_q <= ptr_n;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/i2c_word_ctrl.sv
module i2c_word_ctrl
  import i2c_word_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter logic [6:0] DEV_MASK = 7'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt_i,
  input  logic              sda_s_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic              re_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              ptr_ld_hi_o,
  output logic              ptr_ld_lo_o,
  output logic              ptr_inc_o,
  output logic [BYTE_W-1:0] byte_o
);

  state_t             state_q, state_n;
  role_t              role_q, role_n;
  logic [3:0]         cnt_q, cnt_n;
  logic [BYTE_W-1:0]  sh_q, sh_n, hi_q, hi_n;
  logic [WORD_W-1:0]  wdata_q, wdata_n, txw_q;
  logic               oe_q, oe_n, we_q, we_n, re_q, re_n, re_d_q;
  logic               txl_q, txl_n, ack_q, ack_n;
  logic               ld_hi, ld_lo;

  logic [BYTE_W-1:0]  tx_byte;
  logic [2:0]         tx_idx;
  logic               dev_hit;

  assign tx_byte = txl_q ? txw_q[BYTE_W-1:0] : txw_q[WORD_W-1:BYTE_W];
  assign tx_idx  = 3'd6 - cnt_q[2:0];
  assign dev_hit = ((sh_q[7:1] ^ DEV_ADDR) & DEV_MASK) == 7'd0;

  always_comb begin
    state_n = state_q;
    role_n  = role_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    hi_n    = hi_q;
    wdata_n = wdata_q;
    oe_n    = oe_q;
    txl_n   = txl_q;
    ack_n   = ack_q;
    we_n    = 1'b0;
    re_n    = 1'b0;
    ld_hi   = 1'b0;
    ld_lo   = 1'b0;
    if (evt_i.stop) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (evt_i.start) begin
      state_n = ST_RX;
      role_n  = RL_DEV;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
      txl_n   = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (evt_i.scl_rise && cnt_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s_i};
            cnt_n = cnt_q + 4'd1;
          end else if (evt_i.scl_fall && cnt_q == 4'd8) begin
            cnt_n   = 4'd0;
            oe_n    = 1'b1;
            state_n = ST_RX_ACK;
            unique case (role_q)
              RL_DEV: begin
                if (!dev_hit) begin
                  oe_n    = 1'b0;
                  state_n = ST_WAIT;
                end else if (sh_q[0]) begin
                  re_n   = 1'b1;
                  role_n = RL_RD;
                  txl_n  = 1'b0;
                end else begin
                  role_n = RL_PTR_HI;
                end
              end
              RL_PTR_HI: begin
                ld_hi  = 1'b1;
                role_n = RL_PTR_LO;
              end
              RL_PTR_LO: begin
                ld_lo  = 1'b1;
                role_n = RL_DAT_HI;
              end
              RL_DAT_HI: begin
                hi_n   = sh_q;
                role_n = RL_DAT_LO;
              end
              default: begin
                we_n    = 1'b1;
                wdata_n = {hi_q, sh_q};
                role_n  = RL_DAT_HI;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (evt_i.scl_fall) begin
            cnt_n = 4'd0;
            if (role_q == RL_RD) begin
              state_n = ST_TX;
              oe_n    = ~txw_q[WORD_W-1];
            end else begin
              state_n = ST_RX;
              oe_n    = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (evt_i.scl_fall) begin
            if (cnt_q == 4'd7) begin
              state_n = ST_TX_ACK;
              oe_n    = 1'b0;
              cnt_n   = 4'd0;
            end else begin
              oe_n  = ~tx_byte[tx_idx];
              cnt_n = cnt_q + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (evt_i.scl_rise) begin
            ack_n = ~sda_s_i;
            re_n  = ~sda_s_i & txl_q;
          end else if (evt_i.scl_fall) begin
            if (!ack_q) begin
              state_n = ST_WAIT;
            end else begin
              state_n = ST_TX;
              txl_n   = ~txl_q;
              oe_n    = txl_q ? ~txw_q[WORD_W-1] : ~txw_q[BYTE_W-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      role_q  <= RL_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      hi_q    <= '0;
      wdata_q <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      re_d_q  <= 1'b0;
      txl_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      role_q  <= role_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      hi_q    <= hi_n;
      wdata_q <= wdata_n;
      oe_q    <= oe_n;
      we_q    <= we_n;
      re_q    <= re_n;
      re_d_q  <= re_q;
      txl_q   <= txl_n;
      ack_q   <= ack_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      txw_q <= '0;
    else if (re_d_q) txw_q <= rdata_i;
  end

  assign sda_oe_o    = oe_q;
  assign we_o        = we_q;
  assign re_o        = re_q;
  assign wdata_o     = wdata_q;
  assign ptr_ld_hi_o = ld_hi;
  assign ptr_ld_lo_o = ld_lo;
  assign ptr_inc_o   = we_q | re_d_q;
  assign byte_o      = sh_q;

endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
  import i2c_word_pkg::*;
#(
  parameter int         ADDR_W      = 10,
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter logic [6:0] DEV_MASK    = 7'h7C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [WORD_W-1:0] reg_rdata_i
);

  logic [1:0]        rst_sh;
  logic              core_rst_n;
  bus_evt_t          evt;
  logic              sda_s;
  logic              ld_hi, ld_lo, inc;
  logic [BYTE_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign core_rst_n = rst_sh[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .evt_o  (evt),
    .sda_s_o(sda_s)
  );

  i2c_word_ctrl #(.DEV_ADDR(DEV_ADDR), .DEV_MASK(DEV_MASK)) u_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .evt_i      (evt),
    .sda_s_i    (sda_s),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o),
    .wdata_o    (reg_wdata_o),
    .ptr_ld_hi_o(ld_hi),
    .ptr_ld_lo_o(ld_lo),
    .ptr_inc_o  (inc),
    .byte_o     (rx_byte)
  );

  i2c_reg_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .ld_hi_i(ld_hi),
    .ld_lo_i(ld_lo),
    .inc_i  (inc),
    .byte_i (rx_byte),
    .ptr_o  (reg_addr_o)
  );

endmodule

// File: rtl/i2c_word_target_chk.sv
module i2c_word_target_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              reg_we_o,
  input logic              reg_re_o,
  input logic [ADDR_W-1:0] reg_addr_o
);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);                                    // R11
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o));                                          // R12
  AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re_o |=> !reg_re_o);                                           // R12
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);                                           // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> reg_addr_o == ADDR_W'($past(reg_addr_o) + 1'b1));    // R6

endmodule

bind i2c_word_target i2c_word_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_re_o  (reg_re_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/tb_i2c_word_target.sv
`timescale 1ns/1ps
module tb_i2c_word_target;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl_m = 1'b1, sda_m = 1'b1;
  logic          sda_line, sda_oe, reg_we, reg_re;
  logic [AW-1:0] reg_addr;
  logic [15:0]   reg_wdata, reg_rdata;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [15:0] bank    [DEPTH];
  logic [15:0] ref_mem [DEPTH];
  int exp_a[$], exp_d[$];
  int mptr = 0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_word_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 37 + 16'h0100);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= init_val(i);
      reg_rdata <= '0;
    end else begin
      if (reg_we) bank[reg_addr] <= reg_wdata;
      if (reg_re) reg_rdata <= bank[reg_addr];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sda_oe !== prev_oe) check(scl_m == 1'b0, "R11 oe change while SCL high", sda_oe, prev_oe);
      if (reg_we && reg_re) check(1'b0, "R12 we and re together", 1, 0);
      if (reg_we) begin
        if (exp_a.size() == 0) check(1'b0, "R5 R10 unexpected write", reg_addr, reg_wdata);
        else begin
          check(reg_addr == AW'(exp_a[0]), "R5 write address", reg_addr, exp_a[0]);
          check(reg_wdata == 16'(exp_d[0]), "R5 write data", reg_wdata, exp_d[0]);
          void'(exp_a.pop_front());
          void'(exp_d.pop_front());
        end
      end
    end
    prev_oe = sda_oe;
  end

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic wbyte(input logic [7:0] b, input bit exp_nack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    end
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); a = sda_line; wq(1); scl_m = 1'b0; wq(1);
    check(a == exp_nack, req, a, exp_nack);
  endtask

  task automatic rbyte(output logic [7:0] b, input bit nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1); scl_m = 1'b1; wq(1); b[i] = sda_line; wq(1); scl_m = 1'b0;
    end
    wq(1); sda_m = nack; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    sda_m = 1'b1;
  endtask

  task automatic rword(input bit last, input string req);
    logic [7:0] h, l;
    logic [15:0] e;
    e = ref_mem[mptr];
    rbyte(h, 1'b0);
    rbyte(l, last);
    check({h, l} == e, req, {h, l}, e);
    mptr = (mptr + 1) % DEPTH;
  endtask

  task automatic set_ptr(input logic [7:0] dev, input logic [7:0] ph, input logic [7:0] pl);
    i2c_start();
    wbyte({dev[6:0], 1'b0}, 1'b0, "R2 R3 write header ack");
    wbyte(ph, 1'b0, "R4 pointer high ack");
    wbyte(pl, 1'b0, "R4 pointer low ack");
    mptr = {ph[1:0], pl};
  endtask

  task automatic wword(input logic [15:0] d);
    exp_a.push_back(mptr);
    exp_d.push_back(d);
    ref_mem[mptr] = d;
    wbyte(d[15:8], 1'b0, "R5 data high ack");
    wbyte(d[7:0], 1'b0, "R5 data low ack");
    mptr = (mptr + 1) % DEPTH;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R13 reset outputs", {sda_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(reg_addr == '0, "R13 pointer after reset", reg_addr, 0);

    // two-word write then repeated-start read (R5 R6 R7 R9)
    set_ptr(8'h2C, 8'h00, 8'h05);
    wword(16'h1234);
    wword(16'hABCD);
    i2c_stop();
    check(reg_addr == AW'(7), "R6 pointer after writes", reg_addr, 7);
    set_ptr(8'h2C, 8'h00, 8'h05);
    i2c_rstart();
    wbyte({7'h2C, 1'b1}, 1'b0, "R3 read header ack");
    rword(1'b0, "R7 first word");
    rword(1'b1, "R9 second word");
    i2c_stop();
    check(reg_addr == AW'(7), "R9 pointer after read", reg_addr, 7);

    // separate read after stop (R8)
    i2c_start();
    wbyte({7'h2E, 1'b1}, 1'b0, "R2 read header ack low bits dont care");
    rword(1'b1, "R8 separate read word");
    i2c_stop();

    // don't-care address bits and junk pointer bits (R2 R4)
    set_ptr(8'h2F, 8'hFD, 8'h10);
    wword(16'hBEEF);
    i2c_stop();
    check(reg_addr == AW'(16'h111), "R4 pointer masked", reg_addr, 16'h111);

    // foreign address (R2)
    i2c_start();
    wbyte({7'h3C, 1'b0}, 1'b1, "R2 foreign address nack");
    wbyte(8'h00, 1'b1, "R2 ignored byte");
    wbyte(8'h40, 1'b1, "R2 ignored byte");
    wbyte(8'h99, 1'b1, "R2 ignored byte");
    i2c_stop();
    check(reg_addr == AW'(16'h111), "R2 pointer untouched", reg_addr, 16'h111);

    // aborted half word (R10 R1)
    set_ptr(8'h2C, 8'h00, 8'h20);
    wbyte(8'h55, 1'b0, "R10 high byte ack");
    i2c_stop();
    check(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
    i2c_start();
    wbyte({7'h2C, 1'b1}, 1'b0, "R8 read header ack");
    rword(1'b1, "R10 word unchanged");
    i2c_stop();

    // aborted by repeated start (R1 R10)
    set_ptr(8'h2C, 8'h00, 8'h30);
    wbyte(8'h66, 1'b0, "R10 high byte ack");
    i2c_rstart();
    wbyte({7'h2C, 1'b1}, 1'b0, "R1 header after repeated start");
    rword(1'b1, "R10 word unchanged after restart");
    i2c_stop();

    // wrap (R6)
    set_ptr(8'h2C, 8'hFF, 8'hFF);
    wword(16'h1111);
    wword(16'h2222);
    i2c_stop();
    check(reg_addr == AW'(1), "R6 pointer wrap", reg_addr, 1);
    set_ptr(8'h2C, 8'h03, 8'hFF);
    i2c_rstart();
    wbyte({7'h2C, 1'b1}, 1'b0, "R3 read header ack");
    rword(1'b0, "R9 read at top");
    rword(1'b1, "R6 read after wrap");
    i2c_stop();

    repeat (20) @(negedge clk);
    check(exp_a.size() == 0, "R5 all writes seen", exp_a.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule